// File: doc/BRIEF.md
# Hotplug Slot Status Register Block

This block is a compact 32-bit register file through which host firmware tracks slot hotplug activity on several buses. For each bus it holds three 32-slot bitmaps: slots where a device has been hot-inserted, slots with a pending removal request, and slots that may be removed. A bus-select register picks which bus the bitmap registers expose. The platform side reports hot-insert and removal-request events, and each one raises a single-cycle event pulse toward the interrupt logic.

Firmware acknowledges a removal by writing a slot mask to the eject register. The block acts on the lowest set bit of that mask only. It clears that slot in both bitmaps of the selected bus and, if the slot is removable, issues a one-cycle eject pulse carrying the bus and slot numbers. A legacy mode freezes the select register at a default bus and keeps the inserted bitmap from clearing when it is read. After the asynchronous reset, and again on a synchronous platform reset request, a sequencer drains every pending removal request one slot per cycle and then rebuilds all removable masks from the platform's fixed-slot flags.

Top module: `hp_slot_regs`

## Requirements
- R1: Word offsets: 0x00 inserted bitmap, 0x04 removal-request bitmap, 0x08 eject (reads 0), 0x0C removable bitmap, 0x10 bus select (reset value DEFAULT_BUS). Every read request gives reg_rvalid_o and reg_rdata_o on the cycle after the request.
- R2: An access acts only when reg_be_i is 4'hF, reg_addr_i[1:0] is 0 and reg_addr_i is below 0x14. Any other write has no effect, and any other read returns 0.
- R3: When the select value, taken as unsigned, is not below NUM_BUS (this includes negative values), every read returns 0 and eject writes have no effect.
- R4: Reading 0x00 returns the selected bus's inserted bitmap and clears it. In legacy mode (legacy_i=1) the bitmap is kept.
- R5: A write to 0x10 loads the select register. In legacy mode the select register is loaded with DEFAULT_BUS whatever the data.
- R6: A write to 0x08 with an in-range select takes the lowest set bit s of the data and clears bit s of the selected bus's inserted and removal-request bitmaps. On the next cycle ej_valid_o pulses with ej_bus_o and ej_slot_o = s, unless fixed_mask_i bit bus*32+s is set. A zero mask does nothing.
- R7: A hot-insert event (ins_valid_i) sets bit ins_slot_i of bus ins_bus_i's inserted bitmap and pulses evt_o on the next cycle.
- R8: A removal-request event (rmv_valid_i) sets bit rmv_slot_i of bus rmv_bus_i's removal-request bitmap and pulses evt_o on the next cycle. With no event, evt_o stays low.
- R9: An event that arrives in the same cycle as a clearing read or an eject of the same bit leaves that bit set.
- R10: After rst_ni or a sys_reset_i pulse, busy_o is high. Buses are visited in ascending order, and within a bus pending removal bits are ejected lowest first, one per cycle. Each ejected slot clears both bitmaps and pulses ej_valid_o unless it is fixed. Every removable mask is then set to the inverse of fixed_mask_i, and busy_o falls.
- R11: While busy_o is high, register accesses have no effect and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| legacy_i | input | 1 | Legacy mode strap |
| sys_reset_i | input | 1 | Synchronous platform reset request, starts the drain sequence |
| fixed_mask_i | input | NUM_BUS*32 | Non-removable slot flags, bit bus*32+slot |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 5 | Byte offset in the register window |
| reg_be_i | input | 4 | Byte enables |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data |
| reg_rvalid_o | output | 1 | Read data valid |
| ins_valid_i | input | 1 | Hot-insert event |
| ins_bus_i | input | BUS_W | Bus of the insert event |
| ins_slot_i | input | 5 | Slot of the insert event |
| rmv_valid_i | input | 1 | Removal-request event |
| rmv_bus_i | input | BUS_W | Bus of the removal request |
| rmv_slot_i | input | 5 | Slot of the removal request |
| evt_o | output | 1 | Event interrupt pulse |
| ej_valid_o | output | 1 | Eject pulse |
| ej_bus_o | output | BUS_W | Bus of the eject |
| ej_slot_o | output | 5 | Slot of the eject |
| busy_o | output | 1 | Reset drain sequence in progress |

## Verification
Read data, the event pulse and the eject pulse all come from one register stage. The bench therefore drives a request on a falling edge and samples all three on the next falling edge, one full cycle later. A bitmap changed by an event or an eject is checked with a read issued in the following cycle, whose data arrives one cycle after that. During the drain sequence the bench samples ej_valid_o on every falling edge until busy_o drops. It compares the order of the (bus, slot) pulses with a list derived from the pending bits and the fixed flags.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int unsigned NSLOT  = 32;
  localparam int unsigned SLOT_W = 5;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 5;
  localparam logic [ADDR_W-1:0] WIN_END = 5'h14;

  typedef logic [NSLOT-1:0] slot_mask_t;

  typedef enum logic [2:0] {
    REG_INS       = 3'd0,
    REG_RMREQ     = 3'd1,
    REG_EJECT     = 3'd2,
    REG_REMOVABLE = 3'd3,
    REG_SEL       = 3'd4
  } reg_idx_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_DRAIN,
    SEQ_REBUILD
  } seq_state_e;
endpackage

// File: rtl/hp_lsb_enc.sv
module hp_lsb_enc #(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  in_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |in_i;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (in_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/hp_bus_state.sv
module hp_bus_state import hp_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  slot_mask_t ins_set_i,
  input  slot_mask_t req_set_i,
  input  slot_mask_t clr_i,
  input  logic       ins_rd_clr_i,
  input  logic       rmv_load_i,
  input  slot_mask_t rmv_val_i,
  output slot_mask_t ins_o,
  output slot_mask_t req_o,
  output slot_mask_t rmv_o
);
  slot_mask_t ins_q, req_q, rmv_q;

  // set terms are ORed last so events win over clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ins_q <= '0;
      req_q <= '0;
      rmv_q <= '0;
    end else begin
      ins_q <= (ins_q & ~clr_i & {NSLOT{~ins_rd_clr_i}}) | ins_set_i;
      req_q <= (req_q & ~clr_i) | req_set_i;
      if (rmv_load_i) rmv_q <= rmv_val_i;
    end
  end

  assign ins_o = ins_q;
  assign req_o = req_q;
  assign rmv_o = rmv_q;

  p_ins_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_set_i != '0) |=> ((ins_o & $past(ins_set_i)) == $past(ins_set_i)));
  p_req_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_set_i != '0) |=> ((req_o & $past(req_set_i)) == $past(req_set_i)));
  p_rd_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_rd_clr_i && ins_set_i == '0) |=> (ins_o == '0));
  p_rmv_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rmv_load_i |=> $stable(rmv_o));
endmodule

// File: rtl/hp_reset_seq.sv
module hp_reset_seq import hp_pkg::*; #(
  parameter int unsigned NUM_BUS = 8,
  parameter int unsigned BUS_W   = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  slot_mask_t        pend_i,
  output logic              busy_o,
  output logic [BUS_W-1:0]  bus_o,
  output logic              drain_ej_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              rebuild_o
);
  localparam logic [BUS_W-1:0] LAST_BUS = BUS_W'(NUM_BUS - 1);

  seq_state_e       state_q;
  logic [BUS_W-1:0] bus_q;
  logic             pend_any;

  hp_lsb_enc #(.W(NSLOT), .IW(SLOT_W)) u_pend_enc (
    .in_i (pend_i),
    .any_o(pend_any),
    .idx_o(slot_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_DRAIN;
      bus_q   <= '0;
    end else if (start_i) begin
      state_q <= SEQ_DRAIN;
      bus_q   <= '0;
    end else begin
      case (state_q)
        SEQ_DRAIN: if (!pend_any) begin
          if (bus_q == LAST_BUS) state_q <= SEQ_REBUILD;
          else                   bus_q   <= bus_q + 1'b1;
        end
        SEQ_REBUILD: state_q <= SEQ_IDLE;
        default:     state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != SEQ_IDLE);
  assign bus_o      = bus_q;
  assign drain_ej_o = (state_q == SEQ_DRAIN) && pend_any;
  assign rebuild_o  = (state_q == SEQ_REBUILD);

  p_drain_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_ej_o && !start_i) |=> (busy_o && bus_o == $past(bus_o)));
  p_rebuild_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rebuild_o && !start_i) |=> !busy_o);
endmodule

// File: rtl/hp_reg_if.sv
module hp_reg_if import hp_pkg::*; #(
  parameter int unsigned NUM_BUS     = 8,
  parameter int unsigned DEFAULT_BUS = 0,
  parameter int unsigned BUS_W       = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              legacy_i,
  input  logic              busy_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  slot_mask_t        cur_ins_i,
  input  slot_mask_t        cur_req_i,
  input  slot_mask_t        cur_rmv_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [BUS_W-1:0]  sel_bus_o,
  output logic              sel_ok_o,
  output logic              ins_rd_clr_o,
  output logic              ej_wr_o,
  output logic [SLOT_W-1:0] ej_slot_o
);
  logic [DATA_W-1:0] sel_q, rdata_q, rd_mux;
  logic              rvalid_q;
  logic              acc_ok, rd, wr, sel_wr, ej_any;
  reg_idx_e          idx;

  assign idx    = reg_idx_e'(addr_i[4:2]);
  assign acc_ok = req_i && !busy_i && (be_i == 4'hF) && (addr_i[1:0] == 2'b00)
                  && (addr_i < WIN_END);
  assign rd     = acc_ok && !we_i;
  assign wr     = acc_ok && we_i;
  assign sel_wr = wr && (idx == REG_SEL);

  assign sel_ok_o  = (sel_q < DATA_W'(NUM_BUS));
  assign sel_bus_o = sel_q[BUS_W-1:0];

  hp_lsb_enc #(.W(DATA_W), .IW(SLOT_W)) u_ej_enc (
    .in_i (wdata_i),
    .any_o(ej_any),
    .idx_o(ej_slot_o)
  );

  assign ej_wr_o      = wr && (idx == REG_EJECT) && sel_ok_o && ej_any;
  assign ins_rd_clr_o = rd && (idx == REG_INS) && sel_ok_o && !legacy_i;

  always_comb begin
    case (idx)
      REG_INS:       rd_mux = cur_ins_i;
      REG_RMREQ:     rd_mux = cur_req_i;
      REG_REMOVABLE: rd_mux = cur_rmv_i;
      REG_SEL:       rd_mux = sel_q;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= DATA_W'(DEFAULT_BUS);
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= req_i && !we_i;
      rdata_q  <= (rd && sel_ok_o) ? rd_mux : '0;
      if (sel_wr) sel_q <= legacy_i ? DATA_W'(DEFAULT_BUS) : wdata_i;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  p_oob_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !sel_ok_o) |=> (rdata_o == '0));
  p_legacy_sel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_wr && legacy_i) |=> (sel_q == DATA_W'(DEFAULT_BUS)));
  p_busy_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && busy_i) |=> (rdata_o == '0 && $stable(sel_q)));
  p_read_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs import hp_pkg::*; #(
  parameter int unsigned NUM_BUS     = 8,
  parameter int unsigned DEFAULT_BUS = 0,
  parameter int unsigned BUS_W       = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     legacy_i,
  input  logic                     sys_reset_i,
  input  logic [NUM_BUS*NSLOT-1:0] fixed_mask_i,
  input  logic                     reg_req_i,
  input  logic                     reg_we_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic [3:0]               reg_be_i,
  input  logic [DATA_W-1:0]        reg_wdata_i,
  output logic [DATA_W-1:0]        reg_rdata_o,
  output logic                     reg_rvalid_o,
  input  logic                     ins_valid_i,
  input  logic [BUS_W-1:0]         ins_bus_i,
  input  logic [SLOT_W-1:0]        ins_slot_i,
  input  logic                     rmv_valid_i,
  input  logic [BUS_W-1:0]         rmv_bus_i,
  input  logic [SLOT_W-1:0]        rmv_slot_i,
  output logic                     evt_o,
  output logic                     ej_valid_o,
  output logic [BUS_W-1:0]         ej_bus_o,
  output logic [SLOT_W-1:0]        ej_slot_o,
  output logic                     busy_o
);
  slot_mask_t ins_w [NUM_BUS];
  slot_mask_t req_w [NUM_BUS];
  slot_mask_t rmv_w [NUM_BUS];

  logic [BUS_W-1:0]  sel_bus, seq_bus, fire_bus;
  logic [SLOT_W-1:0] wr_slot, seq_slot, fire_slot;
  logic              sel_ok, ins_rd_clr, ej_wr, drain_ej, rebuild, fire;
  slot_mask_t        cur_ins, cur_req, cur_rmv;

  assign cur_ins = sel_ok ? ins_w[sel_bus] : '0;
  assign cur_req = sel_ok ? req_w[sel_bus] : '0;
  assign cur_rmv = sel_ok ? rmv_w[sel_bus] : '0;

  hp_reg_if #(.NUM_BUS(NUM_BUS), .DEFAULT_BUS(DEFAULT_BUS), .BUS_W(BUS_W)) u_reg_if (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .legacy_i    (legacy_i),
    .busy_i      (busy_o),
    .req_i       (reg_req_i),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .be_i        (reg_be_i),
    .wdata_i     (reg_wdata_i),
    .cur_ins_i   (cur_ins),
    .cur_req_i   (cur_req),
    .cur_rmv_i   (cur_rmv),
    .rdata_o     (reg_rdata_o),
    .rvalid_o    (reg_rvalid_o),
    .sel_bus_o   (sel_bus),
    .sel_ok_o    (sel_ok),
    .ins_rd_clr_o(ins_rd_clr),
    .ej_wr_o     (ej_wr),
    .ej_slot_o   (wr_slot)
  );

  hp_reset_seq #(.NUM_BUS(NUM_BUS), .BUS_W(BUS_W)) u_reset_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (sys_reset_i),
    .pend_i    (req_w[seq_bus]),
    .busy_o    (busy_o),
    .bus_o     (seq_bus),
    .drain_ej_o(drain_ej),
    .slot_o    (seq_slot),
    .rebuild_o (rebuild)
  );

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    slot_mask_t ins_set, req_set, clr;
    always_comb begin
      ins_set = (ins_valid_i && ins_bus_i == BUS_W'(b)) ? (slot_mask_t'(1) << ins_slot_i) : '0;
      req_set = (rmv_valid_i && rmv_bus_i == BUS_W'(b)) ? (slot_mask_t'(1) << rmv_slot_i) : '0;
      clr     = '0;
      if (ej_wr && sel_bus == BUS_W'(b))      clr = clr | (slot_mask_t'(1) << wr_slot);
      if (drain_ej && seq_bus == BUS_W'(b))   clr = clr | (slot_mask_t'(1) << seq_slot);
    end

    hp_bus_state u_state (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ins_set_i   (ins_set),
      .req_set_i   (req_set),
      .clr_i       (clr),
      .ins_rd_clr_i(ins_rd_clr && sel_bus == BUS_W'(b)),
      .rmv_load_i  (rebuild),
      .rmv_val_i   (~fixed_mask_i[b*NSLOT +: NSLOT]),
      .ins_o       (ins_w[b]),
      .req_o       (req_w[b]),
      .rmv_o       (rmv_w[b])
    );
  end

  // register writes are blocked while draining, so the two sources never collide
  assign fire_bus  = ej_wr ? sel_bus : seq_bus;
  assign fire_slot = ej_wr ? wr_slot : seq_slot;
  assign fire      = (ej_wr || drain_ej) && !fixed_mask_i[{fire_bus, fire_slot}];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_o      <= 1'b0;
      ej_valid_o <= 1'b0;
      ej_bus_o   <= '0;
      ej_slot_o  <= '0;
    end else begin
      evt_o      <= ins_valid_i || rmv_valid_i;
      ej_valid_o <= fire;
      if (fire) begin
        ej_bus_o  <= fire_bus;
        ej_slot_o <= fire_slot;
      end
    end
  end

  p_evt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i || rmv_valid_i) |=> evt_o);
  p_evt_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ins_valid_i || rmv_valid_i) |=> !evt_o);
  p_ej_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ej_valid_o |-> $past(ej_wr || drain_ej));
  p_no_wr_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ej_wr);
endmodule

// File: tb/hp_slot_regs_tb.sv
`timescale 1ns/1ps
module hp_slot_regs_tb;
  localparam int NB = 8;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_INS = 2'd2, OP_RMV = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  addr;   // bus number for INS/RMV
    logic [31:0] data;   // slot for INS/RMV
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{OP_RD,  5'h0C, 32'h0, 32'hFFFF_FFFB, 4'd10}, // R10 removable = ~fixed
    '{OP_RD,  5'h10, 32'h0, 32'h0,         4'd1},  // R1 select reset value
    '{OP_INS, 5'd0,  32'd5, 32'h0,         4'd7},
    '{OP_RD,  5'h00, 32'h0, 32'h20,        4'd7},  // R7
    '{OP_RD,  5'h00, 32'h0, 32'h0,         4'd4},  // R4 cleared by read
    '{OP_RMV, 5'd0,  32'd9, 32'h0,         4'd8},
    '{OP_RD,  5'h04, 32'h0, 32'h200,       4'd8},  // R8
    '{OP_WR,  5'h10, 32'd3, 32'h0,         4'd5},
    '{OP_RD,  5'h10, 32'h0, 32'd3,         4'd5},  // R5
    '{OP_RD,  5'h0C, 32'h0, 32'h7FFF_FFFF, 4'd10}, // R10
    '{OP_RD,  5'h08, 32'h0, 32'h0,         4'd1},  // R1 eject reads 0
    '{OP_INS, 5'd3,  32'd31,32'h0,         4'd7},
    '{OP_RD,  5'h00, 32'h0, 32'h8000_0000, 4'd7},  // R7
    '{OP_WR,  5'h10, 32'd8, 32'h0,         4'd3},
    '{OP_RD,  5'h10, 32'h0, 32'h0,         4'd3},  // R3
    '{OP_RD,  5'h0C, 32'h0, 32'h0,         4'd3},  // R3
    '{OP_WR,  5'h10, 32'hFFFF_FFFF, 32'h0, 4'd3},
    '{OP_RD,  5'h04, 32'h0, 32'h0,         4'd3},  // R3 negative select
    '{OP_WR,  5'h10, 32'd0, 32'h0,         4'd5},
    '{OP_RD,  5'h04, 32'h0, 32'h200,       4'd8}   // R8 bit kept
  };

  logic clk = 1'b0, rst_ni = 1'b0, legacy = 1'b0, sys_reset = 1'b0;
  logic [NB*32-1:0] fixed = '0;
  logic req = 0, we = 0;
  logic [4:0] addr = '0;
  logic [3:0] be = 4'hF;
  logic [31:0] wdata = '0, rdata;
  logic rvalid, ins_v = 0, rmv_v = 0, evt, ej_v, busy;
  logic [2:0] ins_b = '0, rmv_b = '0, ej_b;
  logic [4:0] ins_s = '0, rmv_s = '0, ej_s;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  hp_slot_regs #(.NUM_BUS(NB), .DEFAULT_BUS(0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .legacy_i(legacy), .sys_reset_i(sys_reset),
    .fixed_mask_i(fixed), .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_be_i(be), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .reg_rvalid_o(rvalid),
    .ins_valid_i(ins_v), .ins_bus_i(ins_b), .ins_slot_i(ins_s),
    .rmv_valid_i(rmv_v), .rmv_bus_i(rmv_b), .rmv_slot_i(rmv_s),
    .evt_o(evt), .ej_valid_o(ej_v), .ej_bus_o(ej_b), .ej_slot_o(ej_s), .busy_o(busy));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    req = 0; we = 0; be = 4'hF; ins_v = 0; rmv_v = 0; sys_reset = 0;
  endtask

  task automatic set_rd(input logic [4:0] a);
    req = 1; we = 0; addr = a;
  endtask
  task automatic set_wr(input logic [4:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
  endtask
  task automatic set_ins(input logic [2:0] b, input logic [4:0] s);
    ins_v = 1; ins_b = b; ins_s = s;
  endtask
  task automatic set_rmv(input logic [2:0] b, input logic [4:0] s);
    rmv_v = 1; rmv_b = b; rmv_s = s;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string rq);
    set_rd(a); step();
    chk(rvalid && rdata == exp, rq, rdata, exp);
  endtask
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    set_wr(a, d); step();
  endtask

  initial begin
    int got_n;
    logic [7:0] got [4];
    fixed[0*32 +: 32] = 32'h0000_0004;
    fixed[3*32 +: 32] = 32'h8000_0000;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // reset state
    chk(busy && !ej_v && !evt && !rvalid, "R10 reset state",
        {28'h0, busy, ej_v, evt, rvalid}, 32'h8);
    // R11: access during busy
    wr(5'h10, 32'd3);
    rd(5'h10, 32'h0, "R11 read while busy");
    while (busy) @(negedge clk);
    rd(5'h10, 32'h0, "R11 write while busy ignored");

    // vector table
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_RD:  set_rd(VEC[i].addr);
        OP_WR:  set_wr(VEC[i].addr, VEC[i].data);
        OP_INS: set_ins(VEC[i].addr[2:0], VEC[i].data[4:0]);
        default: set_rmv(VEC[i].addr[2:0], VEC[i].data[4:0]);
      endcase
      step();
      if (VEC[i].op == OP_RD)
        chk(rvalid && rdata == VEC[i].exp, $sformatf("R%0d vec %0d", VEC[i].req, i), rdata, VEC[i].exp);
      else if (VEC[i].op != OP_WR)
        chk(evt == 1'b1, $sformatf("R%0d event pulse vec %0d", VEC[i].req, i), {31'h0, evt}, 32'h1);
    end

    // R6 eject lowest bit
    set_ins(3'd0, 5'd9); step();
    wr(5'h08, 32'h0000_0600);
    chk(ej_v && ej_b == 0 && ej_s == 9, "R6 eject pulse", {23'h0, ej_v, ej_b, ej_s}, {23'h0, 1'b1, 3'd0, 5'd9});
    chk(!evt, "R8 no event on write", {31'h0, evt}, 32'h0);
    rd(5'h04, 32'h0, "R6 removal bit cleared");
    rd(5'h00, 32'h0, "R6 inserted bit cleared");
    // R6 fixed slot
    set_ins(3'd0, 5'd2); step();
    wr(5'h08, 32'h4);
    chk(!ej_v, "R6 fixed slot no pulse", {31'h0, ej_v}, 32'h0);
    rd(5'h00, 32'h0, "R6 fixed slot bit cleared");
    // R6 zero mask
    set_ins(3'd0, 5'd7); step();
    wr(5'h08, 32'h0);
    chk(!ej_v, "R6 zero mask", {31'h0, ej_v}, 32'h0);
    rd(5'h00, 32'h80, "R6 zero mask keeps bits");
    // R3 eject with out-of-range select
    set_ins(3'd0, 5'd1); step();
    wr(5'h10, 32'd8);
    wr(5'h08, 32'h2);
    chk(!ej_v, "R3 eject oob", {31'h0, ej_v}, 32'h0);
    wr(5'h10, 32'd0);
    rd(5'h00, 32'h2, "R3 eject oob no clear");
    // R2 partial and out-of-window accesses
    wr(5'h10, 32'd3);
    be = 4'h1; wr(5'h10, 32'd5);
    rd(5'h10, 32'd3, "R2 byte write ignored");
    rd(5'h12, 32'h0, "R2 misaligned read");
    rd(5'h14, 32'h0, "R2 outside window");
    wr(5'h10, 32'd0);
    // R9 event vs clearing read
    set_rd(5'h00); set_ins(3'd0, 5'd4); step();
    chk(rvalid && rdata == 32'h0, "R9 read before set", rdata, 32'h0);
    rd(5'h00, 32'h10, "R9 insert survives read clear");
    // R9 event vs eject
    set_rmv(3'd0, 5'd3); set_wr(5'h08, 32'h8); step();
    chk(ej_v && ej_s == 3, "R9 eject fired", {27'h0, ej_s}, 32'd3);
    rd(5'h04, 32'h8, "R9 removal survives eject");
    // R4/R5 legacy
    legacy = 1;
    wr(5'h10, 32'd5);
    rd(5'h10, 32'd0, "R5 legacy select forced");
    set_ins(3'd0, 5'd1); step();
    rd(5'h00, 32'h2, "R4 legacy read 1");
    rd(5'h00, 32'h2, "R4 legacy read keeps");
    legacy = 0;
    rd(5'h00, 32'h2, "R4 normal read");
    rd(5'h00, 32'h0, "R4 normal read cleared");

    // R10 drain: bus0 slot3 pending, bus1 slots 0,3 pending
    set_rmv(3'd1, 5'd3); step();
    set_rmv(3'd1, 5'd0); set_ins(3'd1, 5'd3); step();
    fixed[1*32 +: 32] = 32'h1;
    sys_reset = 1; step();
    got_n = 0;
    for (int k = 0; k < 40; k++) begin
      if (ej_v) begin
        if (got_n < 4) got[got_n] = {ej_b, ej_s};
        got_n++;
      end
      if (!busy) break;
      @(negedge clk);
    end
    chk(got_n == 2, "R10 drain pulse count", got_n, 2);
    chk(got[0] == {3'd0, 5'd3}, "R10 drain first", {24'h0, got[0]}, {24'h0, 3'd0, 5'd3});
    chk(got[1] == {3'd1, 5'd3}, "R10 drain second", {24'h0, got[1]}, {24'h0, 3'd1, 5'd3});
    chk(!busy, "R10 busy falls", {31'h0, busy}, 32'h0);
    wr(5'h10, 32'd1);
    rd(5'h04, 32'h0, "R10 bus1 requests drained");
    rd(5'h00, 32'h0, "R10 bus1 insert cleared");
    rd(5'h0C, 32'hFFFF_FFFE, "R10 removable rebuilt");

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule